// File: doc/BRIEF.md
# Carry-Save Tree Unsigned Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product in one combinational pass. Every partial-product bit is formed as the AND of one multiplicand bit and one multiplier bit. All N rows exist at once, each shifted by its multiplier bit position and zero-filled to 2N bits.

The rows are reduced by a tree of three-input, two-output carry-save adders. At each level the rows are taken in groups of three. Any one or two rows left over go to the next level unchanged. Reduction stops when two vectors remain. Only those two vectors go through a carry-propagating adder, which is a parallel-prefix look-ahead adder. Because the carry-save adder preserves the arithmetic sum, the grouping can be balanced, and the depth grows with the logarithm base 3/2 of N.

The three-to-two carry-save adder and the look-ahead adder are standalone modules with their own width parameter. Each one is usable and testable on its own.

Top module: `tree_mult`

## Requirements
- R1: For every pair of unsigned operands, `prod_o` equals `a_i * b_i` as an exact 2N-bit value.
- R2: If either operand is zero, `prod_o` is zero.
- R3: With both operands all ones, `prod_o` equals 2^(2N) - 2^(N+1) + 1. For N=8 this is 0xFE01.
- R4: The carry-save adder sets each sum bit k to the XOR of the three input bits k. It sets carry bit k+1 to their majority, and carry bit 0 is zero. As a result, sum + carry equals the sum of the three inputs modulo 2^W.
- R5: In a 4-bit carry-save adder, inputs 3, 2, 0 give sum 0001 and carry 0100. Feeding that sum and carry back in with 3 gives sum 0110 and carry 0010. The look-ahead adder then resolves these two vectors to 1000 (8).
- R6: The look-ahead adder output equals the sum of its two W-bit inputs modulo 2^W.
- R7: Multiplying by one returns the other operand, zero-extended.
- R8: Multiplying by 2^k returns the other operand shifted left by k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | N | Unsigned multiplicand |
| b_i | input | N | Unsigned multiplier |
| prod_o | output | 2N | Unsigned product |

## Verification
Every result of this block is purely combinational, so each output is due in the same clock cycle its operands are applied, with zero register stages on the path. The bench changes the operands just after a falling edge of its clock. It samples the outputs two nanoseconds later, well before the next rising edge, so no check depends on the order of processes at an edge. The same timing is used for the standalone carry-save and look-ahead adder instances, which are driven directly with their own vectors.

// File: rtl/mul_pkg.sv
package mul_pkg;

  // rows produced by one reduction level from r input rows
  function automatic int next_rows(input int r);
    return (r / 3) * 2 + (r % 3);
  endfunction

  // rows present at the input of tree level lvl
  function automatic int rows_at(input int n, input int lvl);
    int r;
    r = n;
    for (int i = 0; i < lvl; i++) r = next_rows(r);
    return r;
  endfunction

  // number of levels needed to reach two rows
  function automatic int tree_levels(input int n);
    int r;
    int c;
    r = n;
    c = 0;
    while (r > 2) begin
      r = next_rows(r);
      c++;
    end
    return c;
  endfunction

endpackage

// File: rtl/csa3to2.sv
module csa3to2 #(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cry_o
);
  logic [W-1:0] maj;

  always_comb begin
    sum_o = x_i ^ y_i ^ z_i;
    maj   = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
    cry_o = {maj[W-2:0], 1'b0};
  end

  // R4
  always_comb begin
    csa_conserve_chk: assert (W'(sum_o + cry_o) == W'(x_i + y_i + z_i))
      else $error("R4 carry-save sum not preserved");
  end
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] sum_o
);
  localparam int L = (W > 1) ? $clog2(W) : 1;

  logic [L:0][W-1:0] gen;
  logic [L:0][W-1:0] prp;
  logic [W-1:0]      half;

  assign half   = x_i ^ y_i;
  assign gen[0] = x_i & y_i;
  assign prp[0] = half;

  // parallel-prefix group generate/propagate, span doubles per level
  for (genvar l = 0; l < L; l++) begin : g_lvl
    localparam int D = 1 << l;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= D) begin : g_comb
        assign gen[l+1][i] = gen[l][i] | (prp[l][i] & gen[l][i-D]);
        assign prp[l+1][i] = prp[l][i] & prp[l][i-D];
      end else begin : g_pass
        assign gen[l+1][i] = gen[l][i];
        assign prp[l+1][i] = prp[l][i];
      end
    end
  end

  assign sum_o = half ^ {gen[L][W-2:0], 1'b0};

  // R6
  always_comb begin
    cla_sum_chk: assert (sum_o == W'(x_i + y_i))
      else $error("R6 look-ahead sum wrong");
  end
endmodule

// File: rtl/csa_tree.sv
module csa_tree #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic [N*W-1:0] rows_i,
  output logic [W-1:0]   vec_a_o,
  output logic [W-1:0]   vec_b_o
);
  import mul_pkg::*;

  localparam int LEVELS = tree_levels(N);

  logic [LEVELS:0][N-1:0][W-1:0] rows;

  assign rows[0] = rows_i;

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int RIN  = rows_at(N, l);
    localparam int GRP  = RIN / 3;
    localparam int LEFT = RIN % 3;
    localparam int ROUT = 2 * GRP + LEFT;
    for (genvar g = 0; g < GRP; g++) begin : g_csa
      csa3to2 #(.W(W)) u_csa (
        .x_i  (rows[l][3*g]),
        .y_i  (rows[l][3*g+1]),
        .z_i  (rows[l][3*g+2]),
        .sum_o(rows[l+1][2*g]),
        .cry_o(rows[l+1][2*g+1])
      );
    end
    for (genvar k = 0; k < LEFT; k++) begin : g_left
      assign rows[l+1][2*GRP+k] = rows[l][3*GRP+k];
    end
    for (genvar k = ROUT; k < N; k++) begin : g_zero
      assign rows[l+1][k] = '0;
    end
  end

  assign vec_a_o = rows[LEVELS][0];
  assign vec_b_o = rows[LEVELS][1];

  logic [W-1:0] row_total;
  always_comb begin
    row_total = '0;
    for (int j = 0; j < N; j++) row_total = row_total + rows_i[j*W +: W];
  end

  // R1
  always_comb begin
    tree_sum_chk: assert (W'(vec_a_o + vec_b_o) == row_total)
      else $error("R1 tree lost value");
  end
endmodule

// File: rtl/tree_mult.sv
module tree_mult #(
  parameter int N = 8
) (
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic [2*N-1:0] prod_o
);
  localparam int W = 2 * N;

  logic [N*W-1:0] pp_rows;
  logic [W-1:0]   vec_a;
  logic [W-1:0]   vec_b;

  for (genvar j = 0; j < N; j++) begin : g_pp
    assign pp_rows[j*W +: W] = {{N{1'b0}}, a_i & {N{b_i[j]}}} << j;
  end

  csa_tree #(.N(N), .W(W)) u_tree (
    .rows_i (pp_rows),
    .vec_a_o(vec_a),
    .vec_b_o(vec_b)
  );

  cla_adder #(.W(W)) u_cla (
    .x_i  (vec_a),
    .y_i  (vec_b),
    .sum_o(prod_o)
  );

  // R1
  always_comb begin
    prod_exact_chk: assert (prod_o == W'(W'(a_i) * W'(b_i)))
      else $error("R1 product mismatch");
  end

  // R2
  always_comb begin
    if (a_i == '0 || b_i == '0) begin
      zero_prod_chk: assert (prod_o == '0)
        else $error("R2 zero operand gave nonzero");
    end
  end
endmodule

// File: tb/tree_mult_tb_top.sv
module tree_mult_tb_top;
  logic clk;
  int   total;
  int   bad;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  logic [7:0]  a8, b8;
  logic [15:0] p8;
  logic [3:0]  a4, b4;
  logic [7:0]  p4;
  logic [3:0]  cx, cy, cz, cs, cc, cr;
  logic [15:0] wx, wy, wz, ws, wc, lx, ly, ls;

  tree_mult #(.N(8)) dut_i (.a_i(a8), .b_i(b8), .prod_o(p8));
  tree_mult #(.N(4)) dut4_i (.a_i(a4), .b_i(b4), .prod_o(p4));
  csa3to2 #(.W(4)) csa4_i (.x_i(cx), .y_i(cy), .z_i(cz), .sum_o(cs), .cry_o(cc));
  cla_adder #(.W(4)) cla4_i (.x_i(cs), .y_i(cc), .sum_o(cr));
  csa3to2 #(.W(16)) csa16_i (.x_i(wx), .y_i(wy), .z_i(wz), .sum_o(ws), .cry_o(wc));
  cla_adder #(.W(16)) cla16_i (.x_i(lx), .y_i(ly), .sum_o(ls));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic t_zero();
    @(negedge clk); a8 = 8'h00; b8 = 8'h00; settle();
    chk("R2 both zero", 32'(p8), 32'h0);
    @(negedge clk); a8 = 8'hA7; b8 = 8'h00; settle();
    chk("R2 b zero", 32'(p8), 32'h0);
    @(negedge clk); a8 = 8'h00; b8 = 8'hFF; settle();
    chk("R2 a zero", 32'(p8), 32'h0);
  endtask

  task automatic t_allones();
    @(negedge clk); a8 = 8'hFF; b8 = 8'hFF; settle();
    chk("R3 n8 all ones", 32'(p8), 32'hFE01);
    @(negedge clk); a4 = 4'hF; b4 = 4'hF; settle();
    chk("R3 n4 all ones", 32'(p4), 32'hE1);
  endtask

  task automatic t_exhaustive4();
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        @(negedge clk); a4 = 4'(i); b4 = 4'(j); settle();
        chk("R1 n4 exhaustive", 32'(p4), 32'(i * j));
      end
    end
  endtask

  task automatic t_random8();
    for (int k = 0; k < 400; k++) begin
      int x;
      int y;
      x = int'($urandom_range(255));
      y = int'($urandom_range(255));
      @(negedge clk); a8 = 8'(x); b8 = 8'(y); settle();
      chk("R1 n8 random", 32'(p8), 32'(x * y));
    end
  endtask

  task automatic t_identity();
    @(negedge clk); a8 = 8'h5C; b8 = 8'h01; settle();
    chk("R7 times one b", 32'(p8), 32'h5C);
    @(negedge clk); a8 = 8'h01; b8 = 8'hE3; settle();
    chk("R7 times one a", 32'(p8), 32'hE3);
  endtask

  task automatic t_powers();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); a8 = 8'hB5; b8 = 8'(1 << k); settle();
      chk("R8 power of two", 32'(p8), 32'(32'hB5 << k));
    end
  endtask

  task automatic t_csa_vector();
    @(negedge clk); cx = 4'd3; cy = 4'd2; cz = 4'd0; settle();
    chk("R5 step1 sum", 32'(cs), 32'b0001);
    chk("R5 step1 carry", 32'(cc), 32'b0100);
    @(negedge clk); cx = 4'b0001; cy = 4'b0100; cz = 4'd3; settle();
    chk("R5 step2 sum", 32'(cs), 32'b0110);
    chk("R5 step2 carry", 32'(cc), 32'b0010);
    chk("R5 final add", 32'(cr), 32'd8);
  endtask

  task automatic t_csa_random();
    for (int k = 0; k < 100; k++) begin
      logic [15:0] x, y, z, maj;
      x = 16'($urandom); y = 16'($urandom); z = 16'($urandom);
      @(negedge clk); wx = x; wy = y; wz = z; settle();
      maj = (x & y) | (y & z) | (x & z);
      chk("R4 csa sum bits", 32'(ws), 32'(x ^ y ^ z));
      chk("R4 csa carry bits", 32'(wc), 32'({maj[14:0], 1'b0}));
    end
  endtask

  task automatic t_cla();
    for (int k = 0; k < 100; k++) begin
      logic [15:0] x, y;
      x = 16'($urandom); y = 16'($urandom);
      @(negedge clk); lx = x; ly = y; settle();
      chk("R6 cla random", 32'(ls), 32'(16'(x + y)));
    end
    @(negedge clk); lx = 16'hFFFF; ly = 16'h0001; settle();
    chk("R6 cla full ripple", 32'(ls), 32'h0);
    @(negedge clk); lx = 16'h7FFF; ly = 16'h0001; settle();
    chk("R6 cla long carry", 32'(ls), 32'h8000);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0;
    bad = 0;
    a8 = '0; b8 = '0; a4 = '0; b4 = '0;
    cx = '0; cy = '0; cz = '0;
    wx = '0; wy = '0; wz = '0; lx = '0; ly = '0;
    t_zero();
    t_allones();
    t_identity();
    t_powers();
    t_exhaustive4();
    t_random8();
    t_csa_vector();
    t_csa_random();
    t_cla();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule